// File: doc/BRIEF.md
# Debounced GPIO Port with Edge Interrupts

This block is an 8-bit general-purpose I/O port that sits behind a small byte-wide register bus. Software sets the output levels, the output enables and the pull-up requests that go to the pad ring. It reads back a cleaned-up copy of every pin. Each incoming pin first crosses into the clock domain through two flops. It is then gated by its input-enable bit and passes a debounce filter. The port has two debounce filters, one for pins 3:0 and one for pins 7:4, each with its own programmable stable time.

The debounced levels feed per-pin edge detectors. Each pin can be set to catch either a rising or a falling edge. A detected edge raises a sticky flag, and software clears a flag by writing 1 to it. The flags that are enabled by the mask are combined into a single interrupt request. A key-combination detector watches a chosen group of the lowest pins and raises a reset request while every pin in that group is held low.

All register writes take effect at the clock edge on which `bus_sel` and `bus_we` are both high. Reads are combinational from `bus_addr`.

Top module: `gpio_dbport`

## Requirements
- R1: After reset, output data, output enable, mask, edge select, flags, both filter codes and the key-reset code are 0, and pull-up and input enable are all ones. `irq` and `krst_req` are low.
- R2: The register offsets are: 0 level (read-only), 1 output data, 2 output enable, 3 pull-up, 4 input enable, 5 mask, 6 edge select, 7 flags, 8 filter control and 9 key-reset control. Output data, output enable and pull-up appear on `pin_out`, `pin_oe` and `pin_pu`. In the filter control register only bits 6:4 and 2:0 are stored, and in the key-reset register only bits 1:0. All other bits read 0.
- R3: Offset 0 returns the debounced level of each pin. With filter code 0 (bypass), a change driven on `pin_in` appears there on the third rising clock edge.
- R4: For filter code c in 1..7, the debounced level follows the synchronized input only after the input has differed from it for 256·2^(c-1) consecutive clocks. This gives a change on the (256·2^(c-1)+2)-th edge after the pin changes. One cycle of agreement restarts the count.
- R5: Filter control bits 2:0 set the code for pins 3:0 and bits 6:4 set the code for pins 7:4. Each half is timed on its own.
- R6: When the debounced level of a pin changes in the direction chosen by its edge-select bit (1 = falling, 0 = rising), that pin's flag bit is set. The flag appears in the same cycle as the new level.
- R7: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it as it was.
- R8: `irq` is high exactly when some bit is set in both the flags and the mask.
- R9: A pin whose input-enable bit is 0 reads as 0. It never sets its flag, and it never counts as low for the key-reset detector.
- R10: With key-reset code 1, 2 or 3, `krst_req` is high while debounced pins 1:0, 2:0 or 3:0 respectively are all low and input-enabled. Code 0 keeps it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Output data to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up request |
| irq | output | 1 | Combined interrupt request |
| krst_req | output | 1 | Key-combination reset request |

## Verification
A debounce counter that is out of step shows up at offset 0 as a level that changes one or more edges away from the 258th or 514th edge. That same misplaced change also moves the flag, because the flag is set in the same cycle as the level. A wrong flag-update term shows up on the next read of offset 7 or at `irq` one cycle after the triggering edge. This covers a lost clear, a wrong edge polarity, and a set that ignores input enable. A wrong key-group decode is visible at `krst_req` right after the code write or right after the third edge from a pin change.

// File: rtl/gpio_dbport_pkg.sv
package gpio_dbport_pkg;

    typedef enum logic [3:0] {
        RA_LEVEL = 4'd0,
        RA_DOUT  = 4'd1,
        RA_OE    = 4'd2,
        RA_PU    = 4'd3,
        RA_IEN   = 4'd4,
        RA_MASK  = 4'd5,
        RA_EDGE  = 4'd6,
        RA_FLAG  = 4'd7,
        RA_FILT  = 4'd8,
        RA_KEY   = 4'd9
    } gpio_reg_e;

    localparam int FCODE_W = 3;
    localparam int KCODE_W = 2;

endpackage

// File: rtl/gpio_dbport_sync.sv
module gpio_dbport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_dbport_filt.sv
module gpio_dbport_filt #(
    parameter int N          = 4,
    parameter int BASE_SHIFT = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [gpio_dbport_pkg::FCODE_W-1:0] code,
    input  logic [N-1:0]                       raw,
    output logic [N-1:0]                       lvl_q,
    output logic [N-1:0]                       lvl_d
);
    localparam int CW = BASE_SHIFT + 7;

    typedef struct packed {
        logic [N-1:0]         lvl;
        logic [N-1:0][CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] lim;
    int sh;

    always_comb begin
        sh  = BASE_SHIFT + int'(code) - 1;
        lim = (code == '0) ? '0 : CW'((CW'(1) << sh) - CW'(1));
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (raw[i] == st_q.lvl[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == lim) begin
                st_d.lvl[i] = raw[i];
                st_d.cnt[i] = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_q = st_q.lvl;
    assign lvl_d = st_d.lvl;
endmodule

// File: rtl/gpio_dbport_krst.sv
module gpio_dbport_krst #(
    parameter int KEYS = 4
) (
    input  logic [KEYS-1:0]                     lvl,
    input  logic [KEYS-1:0]                     ien,
    input  logic [gpio_dbport_pkg::KCODE_W-1:0] code,
    output logic                                req
);
    logic [KEYS-1:0] low_ok;
    logic [KEYS-1:0] sel;

    always_comb begin
        low_ok = ~lvl & ien;
        for (int i = 0; i < KEYS; i++) begin
            sel[i] = (code != '0) && (i <= int'(code));
        end
        req = (code != '0) && (&(low_ok | ~sel));
    end
endmodule

// File: rtl/gpio_dbport.sv
module gpio_dbport
    import gpio_dbport_pkg::*;
#(
    parameter int W          = 8,
    parameter int GROUP      = 4,
    parameter int BASE_SHIFT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu,
    output logic         irq,
    output logic         krst_req
);
    localparam int NGRP = W / GROUP;
    localparam int KEYS = 4;

    typedef struct packed {
        logic [W-1:0]                    dout;
        logic [W-1:0]                    oe;
        logic [W-1:0]                    pu;
        logic [W-1:0]                    ien;
        logic [W-1:0]                    msk;
        logic [W-1:0]                    edg;
        logic [W-1:0]                    flg;
        logic [NGRP-1:0][FCODE_W-1:0]    fcode;
        logic [KCODE_W-1:0]              kcode;
    } regs_t;

    localparam regs_t REGS_RST = '{dout: '0, oe: '0, pu: '1, ien: '1, msk: '0,
                                   edg: '0, flg: '0, fcode: '0, kcode: '0};

    regs_t        regs_d, regs_q;
    logic [W-1:0] sync_lvl;
    logic [W-1:0] raw_g;
    logic [W-1:0] lvl_q;
    logic [W-1:0] lvl_d;
    logic [W-1:0] flg_clr;
    logic [W-1:0] hit;
    logic         wr;

    gpio_dbport_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    assign raw_g = sync_lvl & regs_q.ien;

    for (genvar g = 0; g < NGRP; g++) begin : g_filt
        gpio_dbport_filt #(.N(GROUP), .BASE_SHIFT(BASE_SHIFT)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .code  (regs_q.fcode[g]),
            .raw   (raw_g[g*GROUP +: GROUP]),
            .lvl_q (lvl_q[g*GROUP +: GROUP]),
            .lvl_d (lvl_d[g*GROUP +: GROUP])
        );
    end

    gpio_dbport_krst #(.KEYS(KEYS)) u_krst (
        .lvl  (lvl_q[KEYS-1:0]),
        .ien  (regs_q.ien[KEYS-1:0]),
        .code (regs_q.kcode),
        .req  (krst_req)
    );

    always_comb begin
        regs_d  = regs_q;
        wr      = bus_sel && bus_we;
        flg_clr = (wr && bus_addr == RA_FLAG) ? bus_wdata : '0;
        if (wr) begin
            case (gpio_reg_e'(bus_addr))
                RA_DOUT: regs_d.dout = bus_wdata;
                RA_OE:   regs_d.oe   = bus_wdata;
                RA_PU:   regs_d.pu   = bus_wdata;
                RA_IEN:  regs_d.ien  = bus_wdata;
                RA_MASK: regs_d.msk  = bus_wdata;
                RA_EDGE: regs_d.edg  = bus_wdata;
                RA_FILT: begin
                    for (int g = 0; g < NGRP; g++) begin
                        regs_d.fcode[g] = bus_wdata[g*4 +: FCODE_W];
                    end
                end
                RA_KEY:  regs_d.kcode = bus_wdata[KCODE_W-1:0];
                default: ;
            endcase
        end
        hit = ((lvl_d & ~lvl_q & ~regs_q.edg) | (~lvl_d & lvl_q & regs_q.edg)) & regs_q.ien;
        regs_d.flg = (regs_q.flg & ~flg_clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (gpio_reg_e'(bus_addr))
            RA_LEVEL: bus_rdata = lvl_q;
            RA_DOUT:  bus_rdata = regs_q.dout;
            RA_OE:    bus_rdata = regs_q.oe;
            RA_PU:    bus_rdata = regs_q.pu;
            RA_IEN:   bus_rdata = regs_q.ien;
            RA_MASK:  bus_rdata = regs_q.msk;
            RA_EDGE:  bus_rdata = regs_q.edg;
            RA_FLAG:  bus_rdata = regs_q.flg;
            RA_FILT: begin
                for (int g = 0; g < NGRP; g++) begin
                    bus_rdata[g*4 +: FCODE_W] = regs_q.fcode[g];
                end
            end
            RA_KEY:   bus_rdata[KCODE_W-1:0] = regs_q.kcode;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = regs_q.dout;
    assign pin_oe  = regs_q.oe;
    assign pin_pu  = regs_q.pu;
    assign irq     = |(regs_q.flg & regs_q.msk);
endmodule

// File: rtl/gpio_dbport_chk.sv
module gpio_dbport_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] flg,
    input logic [W-1:0] flg_clr,
    input logic [W-1:0] ien,
    input logic [W-1:0] msk,
    input logic         irq,
    input logic [1:0]   kcode,
    input logic         krst_req,
    input logic [W-1:0] lvl,
    input logic [W-1:0] raw_g
);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flg) & ~$past(flg_clr)) & ~flg) == '0);

    p_flag_needs_ien_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flg & ~$past(flg)) & ~$past(ien)) == '0);

    p_no_irq_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msk == '0) |-> !irq);

    p_level_follows_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl ^ $past(lvl)) & (lvl ^ $past(raw_g))) == '0);

    p_key_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kcode == 2'd0) |-> !krst_req);

    p_key_pins_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        krst_req |-> (!lvl[0] && !lvl[1] && ien[0] && ien[1]));
endmodule

bind gpio_dbport gpio_dbport_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flg      (regs_q.flg),
    .flg_clr  (flg_clr),
    .ien      (regs_q.ien),
    .msk      (regs_q.msk),
    .irq      (irq),
    .kcode    (regs_q.kcode),
    .krst_req (krst_req),
    .lvl      (lvl_q),
    .raw_g    (raw_g)
);

// File: tb/sim_gpio_dbport.sv
`timescale 1ns/1ps
module sim_gpio_dbport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;
    logic       irq, krst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_dbport u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .irq(irq), .krst_req(krst_req)
    );

    localparam logic [3:0] A_LVL = 4'd0, A_OUT = 4'd1, A_OE = 4'd2, A_PU = 4'd3,
                           A_IEN = 4'd4, A_MSK = 4'd5, A_EDG = 4'd6, A_FLG = 4'd7,
                           A_FLT = 4'd8, A_KEY = 4'd9;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(string tag, logic [3:0] a, logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, 32'(v), 32'(exp));
    endtask

    task automatic t_reset;
        chk_reg("R1 dout", A_OUT, 8'h00);
        chk_reg("R1 oe", A_OE, 8'h00);
        chk_reg("R1 pu", A_PU, 8'hFF);
        chk_reg("R1 ien", A_IEN, 8'hFF);
        chk_reg("R1 mask", A_MSK, 8'h00);
        chk_reg("R1 edge", A_EDG, 8'h00);
        chk_reg("R1 flags", A_FLG, 8'h00);
        chk_reg("R1 filt", A_FLT, 8'h00);
        chk_reg("R1 key", A_KEY, 8'h00);
        check("R1 pin_pu", 32'(pin_pu), 32'hFF);
        check("R1 pin_oe", 32'(pin_oe), 32'h00);
        check("R1 irq", 32'(irq), 0);
        check("R1 krst_req", 32'(krst_req), 0);
    endtask

    task automatic t_regs;
        wr(A_OUT, 8'hA5); wr(A_OE, 8'h3C); wr(A_PU, 8'h0F);
        check("R2 pin_out", 32'(pin_out), 32'hA5);
        check("R2 pin_oe", 32'(pin_oe), 32'h3C);
        check("R2 pin_pu", 32'(pin_pu), 32'h0F);
        wr(A_FLT, 8'hFF);
        chk_reg("R2 filt reserved", A_FLT, 8'h77);
        wr(A_KEY, 8'hFF);
        chk_reg("R2 key reserved", A_KEY, 8'h03);
        wr(A_FLT, 8'h00); wr(A_KEY, 8'h00);
    endtask

    task automatic t_bypass;
        pin_in = 8'h5A;
        tick(2);
        chk_reg("R3 before third edge", A_LVL, 8'h00);
        tick(1);
        chk_reg("R3 at third edge", A_LVL, 8'h5A);
        wr(A_FLG, 8'hFF);
        chk_reg("R7 clear all", A_FLG, 8'h00);
    endtask

    task automatic t_edges;
        wr(A_EDG, 8'hF0);
        pin_in = 8'hA5;
        tick(3);
        chk_reg("R6 rising low/falling high", A_FLG, 8'h55);
        check("R8 irq masked off", 32'(irq), 0);
        wr(A_MSK, 8'h01);
        check("R8 irq on", 32'(irq), 1);
        wr(A_FLG, 8'h00);
        chk_reg("R7 write 0 keeps", A_FLG, 8'h55);
        wr(A_FLG, 8'h01);
        chk_reg("R7 write 1 clears", A_FLG, 8'h54);
        check("R8 irq off after clear", 32'(irq), 0);
        wr(A_MSK, 8'h10);
        check("R8 irq other bit", 32'(irq), 1);
        wr(A_FLG, 8'hFF);
        check("R8 irq cleared", 32'(irq), 0);
    endtask

    task automatic t_filter;
        wr(A_FLT, 8'h21);
        pin_in = 8'hA4;
        tick(257);
        chk_reg("R4 code1 still old", A_LVL, 8'hA5);
        tick(1);
        chk_reg("R4 code1 changed", A_LVL, 8'hA4);
        pin_in = 8'hA5;
        tick(200);
        pin_in = 8'hA4;
        tick(1);
        pin_in = 8'hA5;
        tick(257);
        chk_reg("R4 bounce restarts count", A_LVL, 8'hA4);
        tick(1);
        chk_reg("R4 after restart", A_LVL, 8'hA5);
        pin_in = 8'h25;
        tick(513);
        chk_reg("R5 high nibble code2 old", A_LVL, 8'hA5);
        tick(1);
        chk_reg("R5 high nibble code2 new", A_LVL, 8'h25);
        wr(A_FLT, 8'h00);
        wr(A_FLG, 8'hFF);
    endtask

    task automatic t_ien;
        wr(A_EDG, 8'h01);
        wr(A_FLG, 8'hFF);
        wr(A_IEN, 8'hFE);
        tick(3);
        chk_reg("R9 disabled pin reads 0", A_LVL, 8'h24);
        chk_reg("R9 no flag on forced fall", A_FLG, 8'h00);
        pin_in = 8'h24; tick(3);
        pin_in = 8'h25; tick(3);
        pin_in = 8'h24; tick(3);
        chk_reg("R9 no flag on disabled toggles", A_FLG, 8'h00);
        wr(A_KEY, 8'h01);
        check("R9 disabled pin not low for key", 32'(krst_req), 0);
        pin_in = 8'h25;
        wr(A_IEN, 8'hFF);
        tick(3);
        check("R10 pin0 high no req", 32'(krst_req), 0);
        pin_in = 8'h24;
        tick(3);
        check("R10 code1 req", 32'(krst_req), 1);
        chk_reg("R6 falling flag when enabled", A_FLG, 8'h01);
        wr(A_FLG, 8'hFF);
    endtask

    task automatic t_key;
        pin_in = 8'hF8;
        tick(3);
        wr(A_KEY, 8'h01); check("R10 code1 pins1:0", 32'(krst_req), 1);
        wr(A_KEY, 8'h02); check("R10 code2 pins2:0", 32'(krst_req), 1);
        wr(A_KEY, 8'h03); check("R10 code3 pin3 high", 32'(krst_req), 0);
        wr(A_KEY, 8'h00); check("R10 code0 off", 32'(krst_req), 0);
        wr(A_KEY, 8'h03);
        pin_in = 8'hF0; tick(3);
        check("R10 code3 all low", 32'(krst_req), 1);
        pin_in = 8'hF4; tick(3);
        check("R10 code3 pin2 high", 32'(krst_req), 0);
        wr(A_KEY, 8'h01);
        check("R10 code1 ignores pin2", 32'(krst_req), 1);
        wr(A_KEY, 8'h02);
        check("R10 code2 pin2 high", 32'(krst_req), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_regs;
        t_bypass;
        t_edges;
        t_filter;
        t_ien;
        t_key;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule